// File: doc/BRIEF.md
# Threshold-Pruned Hard-Decision Viterbi Decoder

This block decodes a rate-1/2, constraint-length-3 convolutional code from hard-decision 2-bit symbols. It accepts one symbol on each cycle where `sym_valid` is high. It does not keep every trellis path alive. Each candidate path is compared against the best survivor of the previous step plus a threshold, and only those that pass are kept. The number of survivors is capped at `NMAX`. When too many candidates pass, the threshold is lowered in steps of two within the same cycle until the count fits. No sorting network is used.

Each survivor slot belongs to one of the four trellis states. A slot holds a metric and a shift register of decided input bits, `HIST` bits deep. After every step the smallest metric is subtracted from all kept metrics, so the previous best is always zero. The decoded bit is the oldest history bit of the lowest-metric survivor. It appears with a one-cycle strobe once `HIST` symbols have been taken in.

A small matching encoder, `cc_k3_encoder`, is also provided. It generates stimulus.

Top module: `thresh_viterbi_dec`

## Requirements
- R1: The encoder holds a state s = {s1,s0}. For input bit b it emits the symbol {b^s1^s0, b^s0}, with bit 1 sent first, and moves to state {b,s1}. From state 00, the inputs 0,1,0 give the symbols 00, 11, 10.
- R2: After reset, `surv_mask` is 4'b0001 (only state 00 survives, metric 0). `dec_valid` is 0, `step_min` is 0 and the threshold equals `T_INIT`.
- R3: A branch costs the Hamming distance between the received symbol and the branch output. A candidate metric is the predecessor metric plus the branch cost. `step_min` shows the smallest candidate metric of the last step, taken before renormalisation. Receiving 00, 11, 11 with the default parameters gives `step_min` values 0, 0, 1.
- R4: The bit n of `surv_mask` marks state n, where n = {s1,s0}. A candidate survives only if its renormalised metric is strictly below the current threshold. The reference point is the previous step's minimum, which is zero after renormalisation.
- R5: When both predecessors of a state are alive, the one with the lower candidate metric is kept. On a tie, the predecessor with the lower state number wins.
- R6: If more than `NMAX` candidates pass, the threshold drops by 2, never going below 0. The test is then repeated in the same cycle. The lowered threshold persists into later steps.
- R7: If no candidate passes the final threshold, exactly one survivor is kept. It is the candidate with the lowest metric, and the lowest state number wins a tie. The survivor count is therefore always between 1 and `NMAX`.
- R8: For the symbol with 0-based index n ≥ HIST-1, `dec_valid` pulses one cycle after that symbol is accepted. `dec_bit` is then the oldest history bit of the best survivor. On an error-free stream it equals the encoder input of symbol n-HIST+1.
- R9: While `sym_valid` is low, `surv_mask`, `step_min` and the threshold hold their values, and `dec_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A received symbol is present this cycle |
| sym | input | 2 | Received hard-decision symbol, bit 1 first code bit |
| dec_valid | output | 1 | One-cycle strobe for `dec_bit` |
| dec_bit | output | 1 | Decoded information bit |
| surv_mask | output | 4 | Survivor occupancy, bit n for trellis state n |
| step_min | output | MW | Minimum candidate metric of the last step |

## Verification
The bench first drives a crowded trellis that forces the threshold down. A design that forgot to tighten would show four survivors in `surv_mask`. A design that tightened only once per step, or reset the threshold each step, would drift from the hand-derived masks in later steps. A second instance with an odd threshold and a cap of two is driven into the case where every candidate fails. A decoder without the single-best fallback would lose all survivors. One that broke the tie the wrong way would keep state 11 instead of state 01. Long noisy streams are run against an independent model of the rules, and this exposes wrong merge tie-breaks and off-by-one decision depth.

// File: rtl/cc_k3_encoder.sv
module cc_k3_encoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic [1:0] code_sym
);
  logic [1:0] st;

  assign code_sym = {bit_in ^ st[1] ^ st[0], bit_in ^ st[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         st <= 2'b00;
    else if (bit_valid) st <= {bit_in, st[1]};

endmodule

// File: rtl/thresh_viterbi_dec.sv
module thresh_viterbi_dec #(
  parameter int NMAX   = 3,
  parameter int T_INIT = 4,
  parameter int HIST   = 15,
  parameter int MW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_valid,
  input  logic [1:0]    sym,
  output logic          dec_valid,
  output logic          dec_bit,
  output logic [3:0]    surv_mask,
  output logic [MW-1:0] step_min
);
  localparam int TSTEPS = T_INIT / 2 + 1;
  localparam int CW = (HIST > 2) ? $clog2(HIST) : 1;
  localparam logic [CW-1:0] FILL_END = CW'(HIST - 1);
  localparam logic [MW-1:0] MSAT = '1;

  logic [3:0][MW-1:0]   pm;
  logic [3:0][HIST-1:0] hist;
  logic [MW-1:0]        thr;
  logic [CW-1:0]        fill;

  logic [3:0]           c_ok;
  logic [3:0][MW-1:0]   c_m;
  logic [3:0][HIST-1:0] c_h;
  logic [MW-1:0]        t_new;
  logic [3:0]           keep, fin;
  logic [1:0]           best;
  logic [MW-1:0]        dmin;

  function automatic logic [1:0] branch_out(input logic [1:0] s, input logic b);
    return {b ^ s[1] ^ s[0], b ^ s[0]};
  endfunction

  function automatic logic [1:0] ham(input logic [1:0] x);
    return {1'b0, x[1]} + {1'b0, x[0]};
  endfunction

  function automatic logic [MW-1:0] sat_add(input logic [MW-1:0] a, input logic [1:0] d);
    logic [MW:0] s;
    s = {1'b0, a} + {{(MW-1){1'b0}}, d};
    return s[MW] ? MSAT : s[MW-1:0];
  endfunction

  for (genvar n = 0; n < 4; n++) begin : g_acs
    localparam logic [1:0] NS = 2'(n);
    localparam logic [1:0] PA = {NS[0], 1'b0};
    localparam logic [1:0] PB = {NS[0], 1'b1};
    logic [MW-1:0] ma, mb;
    logic          pick_b;
    assign ma     = sat_add(pm[PA], ham(sym ^ branch_out(PA, NS[1])));
    assign mb     = sat_add(pm[PB], ham(sym ^ branch_out(PB, NS[1])));
    assign pick_b = surv_mask[PB] && (!surv_mask[PA] || mb < ma);
    assign c_ok[n] = surv_mask[PA] || surv_mask[PB];
    assign c_m[n]  = pick_b ? mb : ma;
    assign c_h[n]  = {pick_b ? hist[PB][HIST-2:0] : hist[PA][HIST-2:0], NS[1]};
  end

  always_comb begin
    int cnt;
    t_new = thr;
    for (int k = 0; k < TSTEPS; k++) begin
      cnt = 0;
      for (int i = 0; i < 4; i++)
        if (c_ok[i] && c_m[i] < t_new) cnt++;
      if (cnt > NMAX) t_new = (t_new >= MW'(2)) ? t_new - MW'(2) : '0;
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    best  = 2'd0;
    for (int i = 0; i < 4; i++)
      if (c_ok[i] && (!found || c_m[i] < c_m[best])) begin
        best  = 2'(i);
        found = 1'b1;
      end
    for (int i = 0; i < 4; i++)
      keep[i] = c_ok[i] && (c_m[i] < t_new);
  end

  assign fin  = (keep != 4'b0) ? keep : (4'b0001 << best);
  assign dmin = c_m[best];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      surv_mask <= 4'b0001;
      pm        <= '0;
      hist      <= '0;
      thr       <= MW'(T_INIT);
      fill      <= '0;
      dec_valid <= 1'b0;
      dec_bit   <= 1'b0;
      step_min  <= '0;
    end else begin
      dec_valid <= 1'b0;
      if (sym_valid) begin
        surv_mask <= fin;
        thr       <= t_new;
        step_min  <= dmin;
        hist      <= c_h;
        for (int i = 0; i < 4; i++)
          pm[i] <= fin[i] ? c_m[i] - dmin : '0;
        dec_valid <= (fill == FILL_END);
        dec_bit   <= c_h[best][HIST-1];
        if (fill != FILL_END) fill <= fill + 1'b1;
      end
    end

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(surv_mask) <= NMAX) && (surv_mask != 4'b0));

  a_r6_thr_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> thr <= $past(thr));

  a_r8_strobe_follows_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(sym_valid));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> $stable(surv_mask) && $stable(step_min) && $stable(thr) && !dec_valid);

  a_r4_best_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> (pm[$past(best)] == '0) && surv_mask[$past(best)]);

endmodule

// File: tb/thresh_viterbi_dec_tb.sv
module thresh_viterbi_dec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [1:0] sym = 2'b00;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic [1:0] enc_sym;
  logic       dv_a, db_a, dv_b, db_b;
  logic [3:0] mk_a, mk_b;
  logic [7:0] sm_a, sm_b;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  thresh_viterbi_dec dut_i (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
    .dec_valid(dv_a), .dec_bit(db_a), .surv_mask(mk_a), .step_min(sm_a));

  thresh_viterbi_dec #(.NMAX(2), .T_INIT(3), .HIST(6), .MW(8)) dut_b (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
    .dec_valid(dv_b), .dec_bit(db_b), .surv_mask(mk_b), .step_min(sm_b));

  cc_k3_encoder enc_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in), .code_sym(enc_sym));

  // {symbol, expected surv_mask, expected step_min} for the default instance
  localparam logic [13:0] VEC [6] = '{
    {2'b00, 4'b0101, 8'd0},
    {2'b11, 4'b0100, 8'd0},
    {2'b11, 4'b1010, 8'd1},
    {2'b00, 4'b1110, 8'd0},
    {2'b00, 4'b1110, 8'd1},
    {2'b00, 4'b1110, 8'd0}
  };

  int m_pm [2][4];
  bit m_al [2][4];
  int m_h  [2][4];
  int m_thr [2];
  int m_fill [2];
  int c_nm [2] = '{3, 2};
  int c_t0 [2] = '{4, 3};
  int c_hl [2] = '{15, 6};
  int e_mask [2];
  int e_min [2];
  int e_bit [2];
  bit e_dv [2];
  bit msg [100];

  function automatic int hd2(int a, int b);
    int x;
    x = (a ^ b) & 3;
    return (x & 1) + (x >> 1);
  endfunction

  function automatic int enc_out(int st, int b);
    return (((b ^ (st >> 1) ^ st) & 1) << 1) | ((b ^ st) & 1);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int u = 0; u < 2; u++) begin
      m_thr[u] = c_t0[u];
      m_fill[u] = 0;
      for (int s = 0; s < 4; s++) begin
        m_pm[u][s] = 0;
        m_al[u][s] = (s == 0);
        m_h[u][s] = 0;
      end
    end
  endtask

  task automatic model_step(int s);
    int cm [4];
    int ch [4];
    bit ok [4];
    bit kp [4];
    int t, cnt, best, mb, pa, b, msk;
    bit any;
    for (int u = 0; u < 2; u++) begin
      for (int n = 0; n < 4; n++) begin
        b = n >> 1;
        pa = (n & 1) * 2;
        ok[n] = 0; cm[n] = 0; ch[n] = 0;
        if (m_al[u][pa]) begin
          ok[n] = 1;
          cm[n] = m_pm[u][pa] + hd2(s, enc_out(pa, b));
          ch[n] = m_h[u][pa];
        end
        if (m_al[u][pa + 1]) begin
          mb = m_pm[u][pa + 1] + hd2(s, enc_out(pa + 1, b));
          if (!ok[n] || mb < cm[n]) begin
            cm[n] = mb;
            ch[n] = m_h[u][pa + 1];
          end
          ok[n] = 1;
        end
        ch[n] = ((ch[n] << 1) | b) & ((1 << c_hl[u]) - 1);
      end
      t = m_thr[u];
      do begin
        cnt = 0;
        for (int n = 0; n < 4; n++) if (ok[n] && cm[n] < t) cnt++;
        if (cnt > c_nm[u]) t = (t >= 2) ? t - 2 : 0;
      end while (cnt > c_nm[u]);
      best = -1;
      for (int n = 0; n < 4; n++)
        if (ok[n] && (best < 0 || cm[n] < cm[best])) best = n;
      any = 0;
      for (int n = 0; n < 4; n++) begin
        kp[n] = ok[n] && (cm[n] < t);
        any |= kp[n];
      end
      msk = 0;
      for (int n = 0; n < 4; n++) begin
        m_al[u][n] = any ? kp[n] : (n == best);
        if (m_al[u][n]) msk |= (1 << n);
        m_pm[u][n] = m_al[u][n] ? cm[n] - cm[best] : 0;
        m_h[u][n] = ch[n];
      end
      m_thr[u] = t;
      e_mask[u] = msk;
      e_min[u] = cm[best];
      e_dv[u] = (m_fill[u] >= c_hl[u] - 1);
      e_bit[u] = (ch[best] >> (c_hl[u] - 1)) & 1;
      if (m_fill[u] < c_hl[u] - 1) m_fill[u]++;
    end
  endtask

  task automatic compare_model();
    chk("R4/R5/R6/R7", "model mask a", mk_a, e_mask[0]);
    chk("R3", "model step_min a", sm_a, e_min[0]);
    chk("R8", "model dec_valid a", dv_a, e_dv[0]);
    if (e_dv[0]) chk("R5/R8", "model dec_bit a", db_a, e_bit[0]);
    chk("R4/R5/R6/R7", "model mask b", mk_b, e_mask[1]);
    chk("R3", "model step_min b", sm_b, e_min[1]);
    chk("R8", "model dec_valid b", dv_b, e_dv[1]);
    if (e_dv[1]) chk("R5/R8", "model dec_bit b", db_b, e_bit[1]);
  endtask

  task automatic send(logic [1:0] s);
    sym = s;
    sym_valid = 1'b1;
    @(posedge clk);
    #2;
    sym_valid = 1'b0;
    model_step(int'(s));
    compare_model();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sym_valid = 1'b0;
    bit_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic finish_up();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    logic [3:0] held_mask;
    logic [7:0] held_min;
    logic [1:0] noise;

    do_reset();
    chk("R2", "reset mask a", mk_a, 1);
    chk("R2", "reset mask b", mk_b, 1);
    chk("R2", "reset dec_valid", dv_a, 0);
    chk("R2", "reset step_min", sm_a, 0);

    for (int i = 0; i < 6; i++) begin
      send(VEC[i][13:12]);
      chk("R3/R4/R6", "table mask", mk_a, VEC[i][11:8]);
      chk("R3/R6", "table step_min", sm_a, VEC[i][7:0]);
    end

    held_mask = mk_a;
    held_min = sm_a;
    repeat (4) begin
      @(posedge clk);
      #2;
      chk("R9", "idle dec_valid", dv_a, 0);
      chk("R9", "idle mask", mk_a, held_mask);
      chk("R9", "idle step_min", sm_a, held_min);
    end
    send(2'b01);

    // R7 and R6 floor on the second instance: 00,11,00,00
    do_reset();
    send(2'b00);
    chk("R6", "b step1 mask", mk_b, 4'b0101);
    send(2'b11);
    chk("R6", "b step2 mask", mk_b, 4'b0101);
    send(2'b00);
    chk("R7", "b fallback mask", mk_b, 4'b0010);
    chk("R7", "b fallback step_min", sm_b, 1);
    send(2'b00);
    chk("R6", "b lowered threshold kept", mk_b, 4'b0100);

    // R1 encoder
    do_reset();
    bit_in = 1'b0;
    #1;
    chk("R1", "encoder sym 1", enc_sym, 0);
    bit_valid = 1'b1;
    @(posedge clk);
    #2;
    bit_in = 1'b1;
    #1;
    chk("R1", "encoder sym 2", enc_sym, 3);
    @(posedge clk);
    #2;
    bit_in = 1'b0;
    #1;
    chk("R1", "encoder sym 3", enc_sym, 2);
    @(posedge clk);
    #2;
    bit_valid = 1'b0;

    // R8 clean stream
    do_reset();
    for (int n = 0; n < 100; n++) begin
      msg[n] = 1'($urandom % 2);
      bit_in = msg[n];
      bit_valid = 1'b1;
      #1;
      send(enc_sym);
      if (n >= 14) begin
        chk("R8", "clean dec_valid", dv_a, 1);
        chk("R8", "clean dec_bit", db_a, msg[n - 14]);
      end else begin
        chk("R8", "early dec_valid", dv_a, 0);
      end
    end
    bit_valid = 1'b0;

    // noisy streams against the rule model
    do_reset();
    for (int n = 0; n < 600; n++) begin
      bit_in = 1'($urandom % 2);
      bit_valid = 1'b1;
      #1;
      noise = {($urandom % 4) == 0, ($urandom % 4) == 0};
      send(enc_sym ^ noise);
      if (($urandom % 10) == 0) begin
        bit_valid = 1'b0;
        @(posedge clk);
        #2;
        chk("R9", "gap dec_valid", dv_a, 0);
      end
    end
    bit_valid = 1'b0;

    finish_up();
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      finish_up();
    end
  end

endmodule